// File: doc/BRIEF.md
# Data Address Generator

This block forms the effective data-space address for an 8-bit RISC core in one pipeline stage. Each request names an addressing mode, a pointer (X, Y or Z), a 6-bit field used as displacement or I/O number, a 16-bit direct address and a write flag. The three 16-bit pointer pairs arrive from the register file. The result carries the effective address, a region code, a flag marking accesses that need two clock cycles, a gated write strobe, the pointer write-back value with its enable and target register, and the program-word address and byte select for constant lookups.

The data map is unified. Working registers, I/O registers and SRAM all appear as ordinary data addresses. Anything above the SRAM is reported as unmapped, and writes to it are blocked.

Requests and results move over valid/ready handshakes. A request is taken on a rising edge where `in_valid` and `in_ready` are both high. Its result is shown with `out_valid` from the next cycle. It stays frozen until a rising edge where `out_ready` is high. `in_ready` equals `!out_valid || out_ready`, so a full stage accepts a new request only in a cycle where its current result leaves. The pointer inputs are sampled when the request is accepted.

Top module: `data_addr_gen`

## Requirements
- R1: Mode codes 0 and 7 (plain indirect) give the selected pointer as the address, with write-back disabled.
- R2: Mode code 1 (post-increment) gives the selected pointer as the address, raises `out_wb_en`, and returns the pointer plus one modulo 65536 as `out_wb_val`.
- R3: Mode code 2 (pre-decrement) gives the pointer minus one modulo 65536 both as the address and as `out_wb_val`, and raises `out_wb_en`.
- R4: Mode code 3 (displacement) gives the selected pointer plus the unsigned 6-bit field (0..63) modulo 65536, with no write-back.
- R5: Mode code 4 (direct) gives `in_direct` as the address.
- R6: Mode code 5 (I/O direct) gives the 6-bit field plus 0x20 as the address.
- R7: The region code is 0 for addresses 0x00-0x1F, 1 for 0x20-0x5F, 2 for 0x60-0xDF and 3 (unmapped) for everything higher. `out_two_cycle` is high exactly for region 2.
- R8: `out_write` equals `in_write`, except that it is forced low when the region is 3 or the mode is 6.
- R9: Mode code 6 (constant lookup) sets the address to Z, `out_const_word` to Z[15:1] and `out_const_hi` to Z[0]. Outside mode 6 both constant outputs are zero.
- R10: Pointer select 0 picks X (low register 26), 1 picks Y (28), and 2 or 3 pick Z (30). When write-back is enabled, `out_wb_idx` is the low register number of the pair. When it is disabled, `out_wb_idx` and `out_wb_val` are zero.
- R11: A result appears with `out_valid` in the cycle after its request is accepted. It holds unchanged while `out_ready` is low. `in_ready` equals `!out_valid || out_ready`.
- R12: After reset, `out_valid` is low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Stage can take a request |
| in_mode | input | 3 | Addressing-mode code |
| in_ptr_sel | input | 2 | Pointer select |
| in_disp | input | 6 | Displacement or I/O number |
| in_direct | input | 16 | Direct address |
| in_write | input | 1 | Request is a write |
| ptr_x | input | 16 | X pair (R27:R26) |
| ptr_y | input | 16 | Y pair (R29:R28) |
| ptr_z | input | 16 | Z pair (R31:R30) |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_addr | output | 16 | Effective address |
| out_region | output | 2 | Region code |
| out_two_cycle | output | 1 | Access needs two cycles (SRAM) |
| out_write | output | 1 | Gated write strobe |
| out_wb_en | output | 1 | Pointer write-back enable |
| out_wb_idx | output | 5 | Low register number of the written pair |
| out_wb_val | output | 16 | New pointer value |
| out_const_word | output | 15 | Program word address for a constant lookup |
| out_const_hi | output | 1 | High byte selected for a constant lookup |

## Verification
The hardest case to reach is a stalled result while the next request is already waiting. The payload must stay frozen, and the waiting request must be taken on exactly the edge where `out_ready` returns. The stimulus drives `out_ready` low at random while keeping `in_valid` high, so a pending request sits behind a stalled result in many cycles. The wrap corners also need directed pointer values: pre-decrement from 0x0000, post-increment from 0xFFFF, and displacement past 0xFFFF. So do the region edges at 0x1F/0x20, 0x5F/0x60 and 0xDF/0xE0, including a write to unmapped space.

// File: rtl/dagu_pkg.sv
package dagu_pkg;
  typedef enum logic [2:0] {
    AM_IND     = 3'd0,
    AM_POSTINC = 3'd1,
    AM_PREDEC  = 3'd2,
    AM_DISP    = 3'd3,
    AM_DIRECT  = 3'd4,
    AM_IO      = 3'd5,
    AM_CONST   = 3'd6,
    AM_IND_ALT = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    RG_REGS = 2'd0,
    RG_IO   = 2'd1,
    RG_SRAM = 2'd2,
    RG_NONE = 2'd3
  } region_e;
endpackage

// File: rtl/dagu_calc.sv
module dagu_calc import dagu_pkg::*; #(
  parameter int AW       = 16,
  parameter int DW       = 6,
  parameter int IO_OFS   = 32,
  parameter int PTR_BASE = 26,
  parameter int IDXW     = 5
) (
  input  logic [2:0]      mode,
  input  logic [1:0]      sel,
  input  logic [DW-1:0]   disp,
  input  logic [AW-1:0]   direct,
  input  logic [AW-1:0]   x,
  input  logic [AW-1:0]   y,
  input  logic [AW-1:0]   z,
  output logic [AW-1:0]   addr,
  output logic            wb_en,
  output logic [IDXW-1:0] wb_idx,
  output logic [AW-1:0]   wb_val,
  output logic            is_const,
  output logic [AW-2:0]   const_word,
  output logic            const_hi
);
  logic [AW-1:0] ptr;
  logic [1:0]    pair;

  always_comb begin
    pair = (sel == 2'd3) ? 2'd2 : sel;
    case (pair)
      2'd0:    ptr = x;
      2'd1:    ptr = y;
      default: ptr = z;
    endcase
  end

  always_comb begin
    addr       = ptr;
    wb_en      = 1'b0;
    wb_val     = '0;
    is_const   = 1'b0;
    const_word = '0;
    const_hi   = 1'b0;
    case (amode_e'(mode))
      AM_POSTINC: begin
        wb_en  = 1'b1;
        wb_val = ptr + AW'(1);
      end
      AM_PREDEC: begin
        addr   = ptr - AW'(1);
        wb_en  = 1'b1;
        wb_val = ptr - AW'(1);
      end
      AM_DISP:   addr = ptr + AW'(disp);
      AM_DIRECT: addr = direct;
      AM_IO:     addr = AW'(disp) + AW'(IO_OFS);
      AM_CONST: begin
        addr       = z;
        is_const   = 1'b1;
        const_word = z[AW-1:1];
        const_hi   = z[0];
      end
      default: ;
    endcase
    wb_idx = wb_en ? IDXW'(PTR_BASE + 2 * int'(pair)) : '0;
  end
endmodule

// File: rtl/dagu_region.sv
module dagu_region import dagu_pkg::*; #(
  parameter int AW         = 16,
  parameter int REG_COUNT  = 32,
  parameter int IO_COUNT   = 64,
  parameter int SRAM_BYTES = 128
) (
  input  logic [AW-1:0] addr,
  output logic [1:0]    region,
  output logic          two_cycle
);
  localparam logic [AW-1:0] IO_BASE   = AW'(REG_COUNT);
  localparam logic [AW-1:0] SRAM_BASE = AW'(REG_COUNT + IO_COUNT);
  localparam logic [AW-1:0] SRAM_LIM  = AW'(REG_COUNT + IO_COUNT + SRAM_BYTES);

  always_comb begin
    if (addr < IO_BASE)        region = RG_REGS;
    else if (addr < SRAM_BASE) region = RG_IO;
    else if (addr < SRAM_LIM)  region = RG_SRAM;
    else                       region = RG_NONE;
    two_cycle = (addr >= SRAM_BASE) && (addr < SRAM_LIM);
  end
endmodule

// File: rtl/dagu_stage.sv
module dagu_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         s_valid,
  output logic         s_ready,
  input  logic [W-1:0] s_data,
  output logic         m_valid,
  input  logic         m_ready,
  output logic [W-1:0] m_data
);
  assign s_ready = !m_valid || m_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_data <= s_data;
    end
  end
endmodule

// File: rtl/data_addr_gen.sv
module data_addr_gen import dagu_pkg::*; #(
  parameter int AW         = 16,
  parameter int DW         = 6,
  parameter int REG_COUNT  = 32,
  parameter int IO_COUNT   = 64,
  parameter int SRAM_BYTES = 128,
  parameter int PTR_BASE   = 26,
  parameter int IDXW       = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [2:0]      in_mode,
  input  logic [1:0]      in_ptr_sel,
  input  logic [DW-1:0]   in_disp,
  input  logic [AW-1:0]   in_direct,
  input  logic            in_write,
  input  logic [AW-1:0]   ptr_x,
  input  logic [AW-1:0]   ptr_y,
  input  logic [AW-1:0]   ptr_z,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [AW-1:0]   out_addr,
  output logic [1:0]      out_region,
  output logic            out_two_cycle,
  output logic            out_write,
  output logic            out_wb_en,
  output logic [IDXW-1:0] out_wb_idx,
  output logic [AW-1:0]   out_wb_val,
  output logic [AW-2:0]   out_const_word,
  output logic            out_const_hi
);
  localparam int PW = AW + 2 + 1 + 1 + 1 + IDXW + AW + (AW - 1) + 1;

  logic [AW-1:0]   c_addr, c_wb_val;
  logic            c_wb_en, c_const, c_hi, c_two, c_write;
  logic [IDXW-1:0] c_idx;
  logic [AW-2:0]   c_word;
  logic [1:0]      c_region;
  logic [PW-1:0]   s_data, m_data;

  dagu_calc #(.AW(AW), .DW(DW), .IO_OFS(REG_COUNT), .PTR_BASE(PTR_BASE), .IDXW(IDXW)) calc_i (
    .mode(in_mode), .sel(in_ptr_sel), .disp(in_disp), .direct(in_direct),
    .x(ptr_x), .y(ptr_y), .z(ptr_z),
    .addr(c_addr), .wb_en(c_wb_en), .wb_idx(c_idx), .wb_val(c_wb_val),
    .is_const(c_const), .const_word(c_word), .const_hi(c_hi)
  );

  dagu_region #(.AW(AW), .REG_COUNT(REG_COUNT), .IO_COUNT(IO_COUNT), .SRAM_BYTES(SRAM_BYTES)) region_i (
    .addr(c_addr), .region(c_region), .two_cycle(c_two)
  );

  assign c_write = in_write && (c_region != RG_NONE) && !c_const;
  assign s_data  = {c_addr, c_region, c_two, c_write, c_wb_en, c_idx, c_wb_val, c_word, c_hi};

  dagu_stage #(.W(PW)) stage_i (
    .clk(clk), .rst_n(rst_n),
    .s_valid(in_valid), .s_ready(in_ready), .s_data(s_data),
    .m_valid(out_valid), .m_ready(out_ready), .m_data(m_data)
  );

  assign {out_addr, out_region, out_two_cycle, out_write, out_wb_en, out_wb_idx,
          out_wb_val, out_const_word, out_const_hi} = m_data;
endmodule

// File: rtl/dagu_chk.sv
module dagu_chk #(
  parameter int AW   = 16,
  parameter int IDXW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [AW-1:0]   out_addr,
  input logic [1:0]      out_region,
  input logic            out_two_cycle,
  input logic            out_write,
  input logic            out_wb_en,
  input logic [IDXW-1:0] out_wb_idx,
  input logic [AW-1:0]   out_wb_val
);
  // R11
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_wb_val) && $stable(out_write));

  // R11
  stall_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);

  // R8
  unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_region == 2'd3 |-> !out_write);

  // R7
  sram_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_two_cycle |-> out_addr >= AW'(96) && out_addr <= AW'(223));

  // R10
  wb_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wb_en |-> out_wb_idx == 5'd26 || out_wb_idx == 5'd28 || out_wb_idx == 5'd30);

  // R2
  wb_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_wb_en |-> out_wb_val == out_addr || out_wb_val == out_addr + AW'(1));
endmodule

bind data_addr_gen dagu_chk #(.AW(AW), .IDXW(IDXW)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_addr(out_addr), .out_region(out_region),
  .out_two_cycle(out_two_cycle), .out_write(out_write), .out_wb_en(out_wb_en),
  .out_wb_idx(out_wb_idx), .out_wb_val(out_wb_val)
);

// File: tb/data_addr_gen_tb.sv
module data_addr_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0, in_write = 1'b0, out_ready = 1'b0;
  logic [2:0]  in_mode = '0;
  logic [1:0]  in_ptr_sel = '0;
  logic [5:0]  in_disp = '0;
  logic [15:0] in_direct = '0, ptr_x = '0, ptr_y = '0, ptr_z = '0;
  logic        in_ready, out_valid, out_two_cycle, out_write, out_wb_en, out_const_hi;
  logic [15:0] out_addr, out_wb_val;
  logic [1:0]  out_region;
  logic [4:0]  out_wb_idx;
  logic [14:0] out_const_word;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // reference state
  bit m_valid = 0;
  int e_addr, e_reg, e_two, e_wr, e_wben, e_idx, e_wbv, e_cw, e_ch;
  string e_tag, e_wtag;

  always #4 clk = ~clk;

  data_addr_gen dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_ptr_sel(in_ptr_sel), .in_disp(in_disp),
    .in_direct(in_direct), .in_write(in_write),
    .ptr_x(ptr_x), .ptr_y(ptr_y), .ptr_z(ptr_z),
    .out_valid(out_valid), .out_ready(out_ready), .out_addr(out_addr),
    .out_region(out_region), .out_two_cycle(out_two_cycle), .out_write(out_write),
    .out_wb_en(out_wb_en), .out_wb_idx(out_wb_idx), .out_wb_val(out_wb_val),
    .out_const_word(out_const_word), .out_const_hi(out_const_hi)
  );

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic model_accept();
    int p, s;
    s = (in_ptr_sel == 2'd3) ? 2 : int'(in_ptr_sel);
    p = (s == 0) ? int'(ptr_x) : (s == 1) ? int'(ptr_y) : int'(ptr_z);
    e_wben = 0; e_wbv = 0; e_idx = 0; e_cw = 0; e_ch = 0; e_wtag = "R2";
    case (in_mode)
      3'd1: begin e_addr = p; e_wben = 1; e_wbv = (p + 1) % 65536; e_tag = "R2"; end
      3'd2: begin e_addr = (p + 65535) % 65536; e_wben = 1; e_wbv = e_addr; e_tag = "R3"; e_wtag = "R3"; end
      3'd3: begin e_addr = (p + int'(in_disp)) % 65536; e_tag = "R4"; end
      3'd4: begin e_addr = int'(in_direct); e_tag = "R5"; end
      3'd5: begin e_addr = int'(in_disp) + 32; e_tag = "R6"; end
      3'd6: begin e_addr = int'(ptr_z); e_cw = int'(ptr_z) / 2; e_ch = int'(ptr_z) % 2; e_tag = "R9"; end
      default: begin e_addr = p; e_tag = "R1"; end
    endcase
    if (e_wben != 0) e_idx = 26 + 2 * s;
    e_reg = (e_addr < 32) ? 0 : (e_addr < 96) ? 1 : (e_addr < 224) ? 2 : 3;
    e_two = (e_reg == 2) ? 1 : 0;
    e_wr  = (in_write && e_reg != 3 && in_mode != 3'd6) ? 1 : 0;
    m_valid = 1;
  endtask

  task automatic compare();
    chk("R11", "out_valid", int'(out_valid), int'(m_valid));
    if (m_valid && out_valid) begin
      chk(e_tag, "addr", int'(out_addr), e_addr);
      chk("R7", "region", int'(out_region), e_reg);
      chk("R7", "two_cycle", int'(out_two_cycle), e_two);
      chk("R8", "write", int'(out_write), e_wr);
      chk(e_wtag, "wb_en", int'(out_wb_en), e_wben);
      chk(e_wtag, "wb_val", int'(out_wb_val), e_wbv);
      chk("R10", "wb_idx", int'(out_wb_idx), e_idx);
      chk("R9", "const_word", int'(out_const_word), e_cw);
      chk("R9", "const_hi", int'(out_const_hi), e_ch);
    end
  endtask

  task automatic step(bit v, int mode, int sel, int disp, int dir, bit wr,
                      int x, int y, int z, bit rdy);
    bit acc;
    @(negedge clk);
    compare();
    in_valid = v; in_mode = 3'(mode); in_ptr_sel = 2'(sel); in_disp = 6'(disp);
    in_direct = 16'(dir); in_write = wr; ptr_x = 16'(x); ptr_y = 16'(y);
    ptr_z = 16'(z); out_ready = rdy;
    #1;
    chk("R11", "in_ready", int'(in_ready), int'(!m_valid || rdy));
    acc = v && (!m_valid || rdy);
    if (acc) model_accept();
    else if (rdy) m_valid = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R12", "out_valid in reset", int'(out_valid), 0);
    chk("R12", "in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12", "out_valid after reset", int'(out_valid), 0);
    // R1 indirect and alias code, pointer selects R10
    step(1, 0, 0, 0, 0, 0, 16'h0010, 16'h0070, 16'h0100, 1);
    step(1, 7, 1, 0, 0, 1, 16'h0010, 16'h0070, 16'h0100, 1);
    step(1, 0, 3, 0, 0, 1, 16'h0010, 16'h0070, 16'h00DF, 1);
    // R2 post-increment with wrap
    step(1, 1, 0, 0, 0, 1, 16'hFFFF, 0, 0, 1);
    step(1, 1, 1, 0, 0, 0, 0, 16'h005F, 0, 1);
    // R3 pre-decrement with wrap
    step(1, 2, 2, 0, 0, 1, 0, 0, 16'h0000, 1);
    step(1, 2, 1, 0, 0, 1, 0, 16'h0060, 0, 1);
    // R4 displacement at 63 and wrap
    step(1, 3, 1, 63, 0, 1, 0, 16'h00A0, 0, 1);
    step(1, 3, 2, 5, 0, 0, 0, 0, 16'hFFFE, 1);
    // R5 direct at region edges, R7/R8
    step(1, 4, 0, 0, 16'h001F, 1, 0, 0, 0, 1);
    step(1, 4, 0, 0, 16'h0020, 1, 0, 0, 0, 1);
    step(1, 4, 0, 0, 16'h00E0, 1, 0, 0, 0, 1);
    step(1, 4, 0, 0, 16'h1234, 1, 0, 0, 0, 1);
    // R6 I/O direct
    step(1, 5, 0, 0, 0, 1, 0, 0, 0, 1);
    step(1, 5, 0, 63, 0, 1, 0, 0, 0, 1);
    // R9 constant lookups
    step(1, 6, 0, 0, 0, 1, 0, 0, 16'h0655, 1);
    step(1, 6, 1, 0, 0, 0, 0, 0, 16'h07FE, 1);
    // R11 stall with pending request
    step(1, 4, 0, 0, 16'h0061, 0, 0, 0, 0, 0);
    step(1, 4, 0, 0, 16'h0062, 0, 0, 0, 0, 0);
    step(1, 4, 0, 0, 16'h0063, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    // random mix with back-pressure
    for (int i = 0; i < 3000; i++) begin
      int pick;
      pick = int'($urandom_range(0, 3));
      step(($urandom_range(0, 3) != 0), int'($urandom_range(0, 7)), int'($urandom_range(0, 3)),
           int'($urandom_range(0, 63)), (pick == 0) ? int'($urandom_range(0, 65535)) : int'($urandom_range(0, 260)),
           bit'($urandom_range(0, 1)),
           (pick == 1) ? int'($urandom_range(0, 65535)) : int'($urandom_range(0, 260)),
           (pick == 2) ? int'($urandom_range(65500, 65535)) : int'($urandom_range(0, 260)),
           (pick == 3) ? int'($urandom_range(0, 65535)) : int'($urandom_range(0, 260)),
           ($urandom_range(0, 2) != 0));
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule